// File: doc/BRIEF.md
# Command-Driven Serial Register Port

This block is the host-facing serial slave of a measurement converter. A host selects it with an active-low select line and clocks bits in on a serial data input. Every transaction starts with an 8-bit command byte. Depending on its top bits, the byte either fires a one-cycle system-operation strobe that carries the byte, opens a 24-bit readout of an addressed register, or opens a 24-bit write to that register.

All serial pins pass through a synchronizer into a faster system clock, and serial clock edges are found in that domain. The block holds a small register array of 24-bit words for testing and reports each committed write on a register-file write port. A write reaches the array only after the 24th data clock. Dropping the select line at any point returns the port to waiting for a command.

Top module: `sreg_port`

## Requirements
- R1: After reset, sdo, op_stb and rf_we are 0, every register reads back as 0, and the port expects a command byte.
- R2: A command byte is taken most-significant bit first, one bit per rising serial clock edge. A byte with bit 7 = 1 pulses op_stb with op_code equal to the byte and causes no register write.
- R3: op_stb is high for exactly one system clock cycle per system-operation command.
- R4: A byte with bit 7 = 0 and bit 6 = 1 selects a write to the register at address bits 5..1. The next 24 bits, MSB first, are committed after the 24th rising edge, and rf_we pulses for one cycle with that address on rf_addr and the word on rf_wdata.
- R5: A byte with bit 7 = 0 and bit 6 = 0 selects a read of the register at address bits 5..1. Its 24 bits appear on sdo MSB first, each one changing after a falling serial clock edge, so the host can sample it before the next rising edge.
- R6: A write whose select is released before the 24th data bit leaves the register unchanged and produces no rf_we pulse.
- R7: Releasing select discards a partly received command byte, and the next 8 bits after reselect are decoded as a fresh command.
- R8: After a finished register transfer, the next 8 bits within the same selection are decoded as a new command.
- R9: While select is released, sdo is 0, and serial clock edges cause no strobe and no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low select from the host |
| sdo | output | 1 | Serial data to the host |
| op_stb | output | 1 | One-cycle system-operation strobe |
| op_code | output | 8 | Command byte that raised the strobe |
| rf_we | output | 1 | One-cycle register commit pulse |
| rf_addr | output | 5 | Address of the committed register |
| rf_wdata | output | 24 | Word committed to the register |

## Verification
The assertions assume that the serial clock runs at least several system cycles per half period. They also assume that sdi is stable around each rising serial edge, so that the synchronized data and clock move together and every edge is seen exactly once. The host model changes sdi only together with a falling serial clock. It holds each level for six system cycles and samples sdo just before raising the serial clock. Select changes only while the serial clock is low.

// File: rtl/sreg_port.sv
module sreg_port #(
  parameter int DATA_W = 24,
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  output logic              sdo,
  output logic              op_stb,
  output logic [CMD_W-1:0]  op_code,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int CNT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {S_CMD, S_RD, S_WR} st_t;

  logic [SYNC_N-1:0] sclk_q, sdi_q, csn_q;
  logic              sclk_prev;
  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd_sh;
  logic [DATA_W-1:0] tx, rx;
  logic [DATA_W-1:0] regs [NREG];

  wire sclk_s  = sclk_q[SYNC_N-1];
  wire sdi_s   = sdi_q[SYNC_N-1];
  wire cs_idle = csn_q[SYNC_N-1];
  wire rise    = sclk_s & ~sclk_prev;
  wire fall    = ~sclk_s & sclk_prev;

  wire [CMD_W-1:0]  cmd_next = {cmd_sh[CMD_W-2:0], sdi_s};
  wire [DATA_W-1:0] rx_next  = {rx[DATA_W-2:0], sdi_s};
  wire [ADDR_W-1:0] cmd_addr = cmd_next[ADDR_W:1];
  wire last_cmd = (cnt == CNT_W'(CMD_W - 1));
  wire last_dat = (cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= '0;
      sdi_q     <= '0;
      csn_q     <= '1;
      sclk_prev <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[SYNC_N-2:0], sclk};
      sdi_q     <= {sdi_q[SYNC_N-2:0], sdi};
      csn_q     <= {csn_q[SYNC_N-2:0], cs_n};
      sclk_prev <= sclk_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_CMD;
      cnt      <= '0;
      cmd_sh   <= '0;
      tx       <= '0;
      rx       <= '0;
      sdo      <= 1'b0;
      op_stb   <= 1'b0;
      op_code  <= '0;
      rf_we    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      op_stb <= 1'b0;
      rf_we  <= 1'b0;
      if (cs_idle) begin
        st  <= S_CMD;
        cnt <= '0;
        sdo <= 1'b0;
      end else begin
        if (fall) begin
          if (st == S_RD) begin
            sdo <= tx[DATA_W-1];
            tx  <= tx << 1;
          end else begin
            sdo <= 1'b0;
          end
        end
        if (rise) begin
          case (st)
            S_CMD: begin
              cmd_sh <= cmd_next;
              if (last_cmd) begin
                cnt <= '0;
                if (cmd_next[CMD_W-1]) begin
                  op_stb  <= 1'b1;
                  op_code <= cmd_next;
                end else begin
                  rf_addr <= cmd_addr;
                  if (cmd_next[CMD_W-2]) begin
                    st <= S_WR;
                  end else begin
                    st <= S_RD;
                    tx <= regs[cmd_addr];
                  end
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_RD: begin
              if (last_dat) begin
                cnt <= '0;
                st  <= S_CMD;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: begin
              rx <= rx_next;
              if (last_dat) begin
                regs[rf_addr] <= rx_next;
                rf_wdata      <= rx_next;
                rf_we         <= 1'b1;
                cnt           <= '0;
                st            <= S_CMD;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_idle,
  input logic       sdo,
  input logic       op_stb,
  input logic [7:0] op_code,
  input logic       rf_we
);
  p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_stb |=> !op_stb);

  p_stb_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_stb |-> op_code[7]);

  p_stb_we_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_stb && rf_we));

  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  p_we_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !$past(cs_idle));

  p_sdo_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !sdo);

  p_stb_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_stb |-> !$past(cs_idle));
endmodule

bind sreg_port sreg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sdo(sdo),
  .op_stb(op_stb), .op_code(op_code), .rf_we(rf_we)
);

// File: tb/sreg_port_bench.sv
module sreg_port_bench;
  localparam int HP = 6;
  localparam int WD_LIMIT = 150000;

  logic clk = 0, rst_n = 0, sclk = 0, sdi = 0, cs_n = 1;
  logic sdo, op_stb, rf_we;
  logic [7:0] op_code;
  logic [4:0] rf_addr;
  logic [23:0] rf_wdata;

  sreg_port u_sreg_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .sdo(sdo), .op_stb(op_stb), .op_code(op_code),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int stb_cnt = 0, we_cnt = 0;
  logic [7:0]  last_code;
  logic [4:0]  last_waddr;
  logic [23:0] last_wdata;
  logic [23:0] exp_mem [32];

  always @(posedge clk) begin
    cyc++;
    if (op_stb) begin stb_cnt++; last_code = op_code; end
    if (rf_we)  begin we_cnt++; last_waddr = rf_addr; last_wdata = rf_wdata; end
    if (cyc == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic r);
    @(negedge clk); sclk = 0; sdi = b;
    repeat (HP) @(negedge clk);
    r = sdo; sclk = 1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic select_on();
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic select_off();
    @(negedge clk); sclk = 0;
    repeat (HP) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
  endtask

  task automatic xfer24(input logic [23:0] w, output logic [23:0] r);
    for (int i = 23; i >= 0; i--) bit_io(w[i], r[i]);
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [23:0] d);
    logic [23:0] dummy;
    select_on();
    send_byte({2'b01, a, 1'b0});
    xfer24(d, dummy);
    select_off();
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [23:0] d);
    select_on();
    send_byte({2'b00, a, 1'b0});
    xfer24(24'h0, d);
    select_off();
  endtask

  localparam logic [28:0] VEC [6] = '{
    {5'd0,  24'hA5C3_0F},
    {5'd1,  24'h80_0001},
    {5'd7,  24'hFF_FFFF},
    {5'd12, 24'h12_3456},
    {5'd30, 24'h00_0001},
    {5'd31, 24'h5A_5A5A}
  };

  initial begin
    logic [23:0] rd, dummy;
    int w0, s0;
    for (int i = 0; i < 32; i++) exp_mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk("R1 sdo", {31'd0, sdo}, 0);
    chk("R1 op_stb", {31'd0, op_stb}, 0);
    chk("R1 rf_we", {31'd0, rf_we}, 0);
    reg_read(5'd31, rd);
    chk("R1 reg reset", {8'd0, rd}, 0);

    for (int i = 0; i < 6; i++) begin
      w0 = we_cnt;
      reg_write(VEC[i][28:24], VEC[i][23:0]);
      exp_mem[VEC[i][28:24]] = VEC[i][23:0];
      chk("R4 we pulse", we_cnt, w0 + 1);
      chk("R4 we addr", {27'd0, last_waddr}, {27'd0, VEC[i][28:24]});
      chk("R4 we data", {8'd0, last_wdata}, {8'd0, VEC[i][23:0]});
    end
    for (int i = 0; i < 6; i++) begin
      reg_read(VEC[i][28:24], rd);
      chk("R5 readback", {8'd0, rd}, {8'd0, exp_mem[VEC[i][28:24]]});
    end

    w0 = we_cnt; s0 = stb_cnt;
    select_on(); send_byte(8'hA5); select_off();
    chk("R2 strobe count", stb_cnt, s0 + 1);
    chk("R2 strobe code", {24'd0, last_code}, 32'hA5);
    select_on(); send_byte(8'hFF); send_byte(8'h80); select_off();
    chk("R3 one strobe per cmd", stb_cnt, s0 + 3);
    chk("R2 last code", {24'd0, last_code}, 32'h80);
    chk("R2 no write", we_cnt, w0);

    w0 = we_cnt;
    select_on();
    send_byte({2'b01, 5'd12, 1'b0});
    for (int i = 0; i < 10; i++) bit_io(1'b1, rd[0]);
    select_off();
    chk("R6 no we", we_cnt, w0);
    reg_read(5'd12, rd);
    chk("R6 reg unchanged", {8'd0, rd}, {8'd0, exp_mem[12]});

    s0 = stb_cnt;
    select_on();
    for (int i = 0; i < 4; i++) bit_io(1'b1, rd[0]);
    select_off();
    reg_write(5'd3, 24'hC0FFEE);
    exp_mem[3] = 24'hC0FFEE;
    chk("R7 no stray strobe", stb_cnt, s0);
    reg_read(5'd3, rd);
    chk("R7 fresh cmd", {8'd0, rd}, {8'd0, 24'hC0FFEE});

    select_on();
    send_byte({2'b01, 5'd9, 1'b0});
    xfer24(24'h3C_96E1, dummy);
    send_byte({2'b00, 5'd9, 1'b0});
    xfer24(24'h0, rd);
    send_byte({2'b00, 5'd1, 1'b0});
    xfer24(24'h0, dummy);
    select_off();
    chk("R8 back-to-back", {8'd0, rd}, {8'd0, 24'h3C96E1});
    chk("R8 second read", {8'd0, dummy}, {8'd0, exp_mem[1]});

    w0 = we_cnt; s0 = stb_cnt;
    for (int i = 0; i < 16; i++) begin
      bit_io(1'b1, rd[0]);
      chk("R9 sdo quiet", {31'd0, rd[0]}, 0);
    end
    @(negedge clk); sclk = 0;
    repeat (8) @(negedge clk);
    chk("R9 no strobe", stb_cnt, s0);
    chk("R9 no write", we_cnt, w0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule